// File: doc/BRIEF.md
# Power-on Self-Test Sequencer

This block runs the processor's built-in self-test after reset. When software or the reset logic pulses `start_i`, the block looks at the configuration flag `test_en_i`. If the flag is clear, the test counts as passed straight away. If the flag is set, the block steps through ten test phases in a fixed order. Each phase lasts a set number of machine cycles, counted only in cycles where `cyc_en_i` is high. On the last machine cycle of each phase, the block samples that phase's external fail line. The real tests are done elsewhere, and this block sees only their fail lines.

A failure does not stop the run. Every remaining phase still runs, and every failure is collected into a 16-bit result word that is later copied into general register R0. When the last phase ends, the block does the following:
- sets the fault-register failure bit if any phase failed;
- raises a level-1 pending-interrupt request if any phase failed (interrupts are still masked during initialisation, so the request is only recorded);
- drives the processor-up pin high only if every phase passed;
- pulses `done_o` for one cycle.

While the test runs, external interrupt and fault events are not latched. Any that were already pending are wiped when the test completes, so normal execution starts with a clean slate.

Top module: `selftest_seq`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `result_o`, `fault_o`, `irq_l1_o`, `npu_o`, `done_o` and `ext_pend_o` are all zero.
- R2: A run executes phases 0 to 9 with lengths 47, 79, 18, 5632, 12, 13, 13, 17, 13 and 15 machine cycles. A clock cycle counts only when `cyc_en_i` is high. With `cyc_en_i` held high, `done_o` is first seen high 5859 clock edges after the edge that accepted `start_i`.
- R3: `phase_fail_i[k]` is sampled only on the final counted cycle of phase k. A failure in phase 0 or phase 1 sets `result_o[7]`. A failure in phase k, for k from 2 to 9, sets `result_o[k+6]`. No other result bit is ever set. Failures from all phases accumulate, because the run continues after a failure.
- R4: `fault_o[0]` stands for fault-register bit 13, `fault_o[1]` for bit 14 and `fault_o[2]` for bit 15. At completion, `fault_o` becomes 3'b001 if any phase failed and 3'b000 otherwise. `fault_o[2:1]` are always zero, so an all-zero `fault_o` means the test passed.
- R5: `npu_o` goes low when a test run is accepted. At completion it goes high only if no phase failed. If `start_i` is accepted with `test_en_i` low, `npu_o` goes high on that same edge.
- R6: At completion, `irq_l1_o` is set exactly when any phase failed. Accepting a new start clears it.
- R7: `done_o` is high for exactly one cycle per run. When `test_en_i` is low at the accepting edge, `done_o` is high in the cycle right after that edge.
- R8: A bit of `ext_evt_i` sets the matching `ext_pend_o` bit only while no test run is in progress. All of `ext_pend_o` is cleared on the completion edge, the same edge that raises `done_o`.
- R9: `start_i` is accepted only when no run is in progress. Accepting it clears `result_o`, `fault_o` and `irq_l1_o`. A `start_i` pulse during a run changes neither the result word nor the completion time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to begin a self-test run |
| test_en_i | input | 1 | Configuration flag: 1 runs the phases, 0 skips them and passes |
| cyc_en_i | input | 1 | Machine-cycle enable for the phase counters |
| phase_fail_i | input | 10 | Fail line of each phase, bit k for phase k |
| ext_evt_i | input | EVT_W (4) | External interrupt/fault event lines |
| result_o | output | 16 | Failure word destined for R0 |
| fault_o | output | 3 | Fault-register bits 13, 14, 15 |
| irq_l1_o | output | 1 | Level-1 pending-interrupt request |
| npu_o | output | 1 | Processor-up indication |
| done_o | output | 1 | One-cycle completion pulse |
| ext_pend_o | output | EVT_W (4) | Latched external events |

## Verification
Every output is registered, so each effect is visible one edge after its cause:
- a start accepted with the test disabled shows `done_o`, `npu_o` and cleared status in the very next cycle;
- a phase failure reaches `result_o` one edge after the last counted cycle of its phase;
- the fault bit, interrupt request, processor-up pin and event clear all appear together with `done_o`, one edge after the final counted cycle.

The bench drives inputs on falling edges and keeps a behavioural model that it advances on each rising edge. It compares every output against that model on every falling edge, half a cycle after the edge that produced the expected value. On top of this, scenario checks count the falling edges from start to `done_o` and check the final words against hand-computed constants.

// File: rtl/selftest_pkg.sv
package selftest_pkg;
  localparam int NPHASE = 10;
  localparam int RES_W  = 16;
  localparam int FT_W   = 3;
  localparam int PH_W   = $clog2(NPHASE);

  // machine cycles taken by each phase
  function automatic int phase_len(input int idx);
    case (idx)
      0:       return 47;
      1:       return 79;
      2:       return 18;
      3:       return 5632;
      4:       return 12;
      5:       return 13;
      6:       return 13;
      7:       return 17;
      8:       return 13;
      default: return 15;
    endcase
  endfunction

  function automatic int longest_phase();
    int m;
    m = 0;
    for (int i = 0; i < NPHASE; i++)
      if (phase_len(i) > m) m = phase_len(i);
    return m;
  endfunction

  localparam int CNT_W = $clog2(longest_phase());

  // result-word bit reporting a failed phase
  function automatic int fail_bit(input int idx);
    return (idx < 2) ? 7 : idx + 6;
  endfunction
endpackage

// File: rtl/selftest_timer.sv
module selftest_timer
  import selftest_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            launch_i,
  input  logic            cyc_en_i,
  output logic            busy_o,
  output logic [PH_W-1:0] phase_o,
  output logic            phase_end_o,
  output logic            last_end_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_lim;

  assign cnt_lim     = CNT_W'(phase_len(int'(phase_o)) - 1);
  assign phase_end_o = busy_o & cyc_en_i & (cnt_q == cnt_lim);
  assign last_end_o  = phase_end_o & (phase_o == PH_W'(NPHASE - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o  <= 1'b0;
      phase_o <= '0;
      cnt_q   <= '0;
    end else if (launch_i) begin
      busy_o  <= 1'b1;
      phase_o <= '0;
      cnt_q   <= '0;
    end else if (busy_o && cyc_en_i) begin
      if (phase_end_o) begin
        cnt_q <= '0;
        if (last_end_o) busy_o  <= 1'b0;
        else            phase_o <= phase_o + 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/selftest_accum.sv
module selftest_accum
  import selftest_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              skip_i,
  input  logic              phase_end_i,
  input  logic              last_end_i,
  input  logic [PH_W-1:0]   phase_i,
  input  logic [NPHASE-1:0] fail_i,
  output logic [RES_W-1:0]  result_o,
  output logic [FT_W-1:0]   fault_o,
  output logic              irq_o,
  output logic              npu_o,
  output logic              done_o
);
  logic             cur_fail;
  logic [RES_W-1:0] fail_mask;
  logic [RES_W-1:0] res_d;
  logic             any_fail;

  assign cur_fail  = phase_end_i & fail_i[phase_i];
  assign fail_mask = RES_W'(1) << fail_bit(int'(phase_i));
  assign res_d     = cur_fail ? (result_o | fail_mask) : result_o;
  assign any_fail  = (res_d != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_o <= '0;
      fault_o  <= '0;
      irq_o    <= 1'b0;
      npu_o    <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (clear_i) begin
        result_o <= '0;
        fault_o  <= '0;
        irq_o    <= 1'b0;
        npu_o    <= skip_i;
        done_o   <= skip_i;
      end else begin
        result_o <= res_d;
        if (last_end_i) begin
          fault_o <= FT_W'(any_fail);
          irq_o   <= any_fail;
          npu_o   <= ~any_fail;
          done_o  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/selftest_evfilt.sv
module selftest_evfilt #(
  parameter int EVT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy_i,
  input  logic             wipe_i,
  input  logic [EVT_W-1:0] evt_i,
  output logic [EVT_W-1:0] pend_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pend_o <= '0;
    else if (wipe_i) pend_o <= '0;
    else if (!busy_i) pend_o <= pend_o | evt_i;
  end
endmodule

// File: rtl/selftest_seq.sv
module selftest_seq
  import selftest_pkg::*;
#(
  parameter int EVT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              test_en_i,
  input  logic              cyc_en_i,
  input  logic [NPHASE-1:0] phase_fail_i,
  input  logic [EVT_W-1:0]  ext_evt_i,
  output logic [RES_W-1:0]  result_o,
  output logic [FT_W-1:0]   fault_o,
  output logic              irq_l1_o,
  output logic              npu_o,
  output logic              done_o,
  output logic [EVT_W-1:0]  ext_pend_o
);
  logic            busy;
  logic [PH_W-1:0] phase;
  logic            phase_end;
  logic            last_end;
  logic            start_fire;
  logic            skip_fire;
  logic            finish;

  assign start_fire = start_i & ~busy;
  assign skip_fire  = start_fire & ~test_en_i;
  assign finish     = last_end | skip_fire;

  selftest_timer u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .launch_i   (start_fire & test_en_i),
    .cyc_en_i   (cyc_en_i),
    .busy_o     (busy),
    .phase_o    (phase),
    .phase_end_o(phase_end),
    .last_end_o (last_end)
  );

  selftest_accum u_accum (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (start_fire),
    .skip_i     (skip_fire),
    .phase_end_i(phase_end),
    .last_end_i (last_end),
    .phase_i    (phase),
    .fail_i     (phase_fail_i),
    .result_o   (result_o),
    .fault_o    (fault_o),
    .irq_o      (irq_l1_o),
    .npu_o      (npu_o),
    .done_o     (done_o)
  );

  selftest_evfilt #(.EVT_W(EVT_W)) u_evfilt (
    .clk   (clk),
    .rst_n (rst_n),
    .busy_i(busy),
    .wipe_i(finish),
    .evt_i (ext_evt_i),
    .pend_o(ext_pend_o)
  );
endmodule

// File: rtl/selftest_seq_chk.sv
module selftest_seq_chk
  import selftest_pkg::*;
#(
  parameter int EVT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [RES_W-1:0] result_o,
  input logic [FT_W-1:0]  fault_o,
  input logic             irq_l1_o,
  input logic             npu_o,
  input logic             done_o,
  input logic [EVT_W-1:0] ext_pend_o,
  input logic             busy,
  input logic             phase_end,
  input logic             start_fire
);
  assert_run_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done_o);

  assert_result_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!phase_end && !start_fire) |=> $stable(result_o));

  assert_ft_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o[2:1] == 2'b00);

  assert_ft_moves_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fault_o) |-> (done_o || $past(start_fire)));

  assert_npu_vs_ft_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (npu_o == !fault_o[0]));

  assert_irq_vs_ft_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (irq_l1_o == fault_o[0]));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_pend_wiped_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (ext_pend_o == '0));

  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_i && !phase_end) |=> $stable(result_o));
endmodule

bind selftest_seq selftest_seq_chk #(.EVT_W(EVT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .result_o  (result_o),
  .fault_o   (fault_o),
  .irq_l1_o  (irq_l1_o),
  .npu_o     (npu_o),
  .done_o    (done_o),
  .ext_pend_o(ext_pend_o),
  .busy      (busy),
  .phase_end (phase_end),
  .start_fire(start_fire)
);

// File: tb/tb_selftest_seq.sv
`timescale 1ns/1ps
module tb_selftest_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        test_en = 1'b0;
  logic        cyc_en = 1'b0;
  logic [9:0]  fail = '0;
  logic [3:0]  evt = '0;
  logic [15:0] result;
  logic [2:0]  fault;
  logic        irq, npu, done;
  logic [3:0]  pend;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  selftest_seq dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .test_en_i(test_en),
    .cyc_en_i(cyc_en), .phase_fail_i(fail), .ext_evt_i(evt),
    .result_o(result), .fault_o(fault), .irq_l1_o(irq), .npu_o(npu),
    .done_o(done), .ext_pend_o(pend)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int          dur [10] = '{47, 79, 18, 5632, 12, 13, 13, 17, 13, 15};
  bit          m_busy, m_done, m_npu, m_irq;
  int          m_ph, m_cnt;
  logic [15:0] m_res;
  logic [2:0]  m_ft;
  logic [3:0]  m_pend;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_npu = 0; m_irq = 0;
      m_ph = 0; m_cnt = 0; m_res = '0; m_ft = '0; m_pend = '0;
    end else begin
      bit was_busy, fin;
      was_busy = m_busy;
      fin = 0;
      if (start && !m_busy) begin
        m_res = '0; m_ft = '0; m_irq = 0; m_npu = 0;
        if (test_en) begin
          m_busy = 1; m_ph = 0; m_cnt = 0;
        end else begin
          m_npu = 1; fin = 1;
        end
      end else if (m_busy && cyc_en) begin
        if (m_cnt == dur[m_ph] - 1) begin
          if (fail[m_ph]) m_res[(m_ph < 2) ? 7 : m_ph + 6] = 1'b1;
          m_cnt = 0;
          if (m_ph == 9) begin
            m_busy = 0; fin = 1;
            m_ft = (m_res != 0) ? 3'b001 : 3'b000;
            m_irq = (m_res != 0);
            m_npu = (m_res == 0);
          end else begin
            m_ph = m_ph + 1;
          end
        end else begin
          m_cnt = m_cnt + 1;
        end
      end
      m_done = fin;
      if (fin) m_pend = '0;
      else if (!was_busy) m_pend = m_pend | evt;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R3 model result", 32'(result), 32'(m_res));
      check("R4 model fault", 32'(fault), 32'(m_ft));
      check("R5 model npu", 32'(npu), 32'(m_npu));
      check("R6 model irq", 32'(irq), 32'(m_irq));
      check("R7 model done", 32'(done), 32'(m_done));
      check("R8 model pend", 32'(pend), 32'(m_pend));
    end
  end

  // ---------------- stimulus ----------------
  task automatic run(input bit ten, input logic [9:0] fv, input int pct,
                     input bit tog, input int restart_at, output int cycles);
    @(negedge clk);
    start = 1; test_en = ten; fail = fv; cyc_en = 1;
    @(negedge clk);
    start = 0;
    if (ten) check("R9 result cleared on start", 32'(result), 32'h0);
    cycles = 0;
    while (!done) begin
      cyc_en = ($urandom_range(99) < pct);
      if (tog) fail = 10'($urandom);
      evt   = ($urandom_range(9) == 0) ? 4'($urandom) : 4'h0;
      start = (cycles == restart_at);
      @(negedge clk);
      cycles++;
    end
    start = 0; evt = '0;
  endtask

  initial begin
    int cyc;
    repeat (3) @(negedge clk);
    check("R1 reset result", 32'(result), 32'h0);
    check("R1 reset flags", 32'({fault, irq, npu, done, pend}), 32'h0);
    rst_n = 1;
    @(negedge clk);
    check("R1 after reset", 32'({result, fault, irq, npu, done, pend}), 32'h0);

    evt = 4'b0101;
    @(negedge clk);
    evt = 4'b0000;
    check("R8 idle event latched", 32'(pend), 32'h5);

    run(0, '0, 100, 0, -1, cyc);
    check("R7 skip done next cycle", 32'(cyc), 32'd0);
    check("R5 skip npu high", 32'(npu), 32'd1);
    check("R8 pend wiped at done", 32'(pend), 32'h0);
    @(negedge clk);
    check("R7 done single cycle", 32'(done), 32'd0);

    run(1, '0, 100, 0, -1, cyc);
    check("R2 run length", 32'(cyc), 32'd5859);
    check("R4 pass fault zero", 32'(fault), 32'h0);
    check("R5 pass npu high", 32'(npu), 32'd1);
    check("R6 pass no irq", 32'(irq), 32'd0);
    check("R8 pend wiped", 32'(pend), 32'h0);

    run(1, 10'b10_0000_1011, 100, 0, -1, cyc);
    check("R3 multi-fail word", 32'(result), 32'h8280);
    check("R4 fail fault bit13", 32'(fault), 32'h1);
    check("R5 fail npu low", 32'(npu), 32'd0);
    check("R6 fail irq set", 32'(irq), 32'd1);

    run(1, 10'b00_0000_0010, 60, 0, -1, cyc);
    check("R3 phase1 maps to bit7", 32'(result), 32'h0080);
    check("R2 stretched run not shorter", 32'(cyc >= 5859), 32'd1);

    run(1, 10'b00_0000_0100, 100, 0, -1, cyc);
    check("R3 phase2 maps to bit8", 32'(result), 32'h0100);

    run(1, '0, 100, 0, 100, cyc);
    check("R9 restart ignored timing", 32'(cyc), 32'd5859);
    check("R9 restart ignored result", 32'(result), 32'h0);

    run(1, '0, 50, 1, 3000, cyc);
    check("R2 random run finished", 32'(done), 32'd1);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule